// File: doc/BRIEF.md
# Memory-Mapped Event Counter Unit

A performance-monitoring block with eight 64-bit counters behind a simple single-cycle register bus. Each counter watches one of 256 event lines. The event lines form a vector of single-cycle pulses indexed by event code. Code zero is special: it counts every clock. A counter advances only when a global run bit and its own enable bit are both set.

When a counter wraps from all ones to zero, it sets a sticky status bit. Status bits whose mask bit is clear are ORed onto the interrupt output. Software clears status bits by writing ones to a separate clear register. The block also holds a read-only version word and a power-management override bit, which it drives out to the surrounding logic.

The bus carries 32-bit and 64-bit accesses. Read data is combinational from the address in the same cycle. A write takes effect at the clock edge on which `bus_valid` and `bus_write` are high.

Top module: `evt_counter_unit`

## Requirements
- R1: After reset, all counters, the run bit, the enable bits, the status bits, the select words and the configuration bit read 0. The mask register at 0x1C70 reads 0xFF and `irq` is low.
- R2: Counter n is at byte address 0x1D00+8n.
  - A 64-bit access (`bus_wide`=1) there reads or writes all 64 bits.
  - A 32-bit access at 0x1D00+8n reaches bits 31:0 of the counter, and one at 0x1D04+8n reaches bits 63:32. In both cases the data sits in bus bits 31:0.
- R3: Counter n increments by one on a clock edge only when all three hold: bit 0 of 0x1C00 (run) is 1, bit n of 0x1C04 (enable) is 1, and its selected event is present.
- R4: Counters 0–3 take their 8-bit event code from the word at 0x1C80 and counters 4–7 from the word at 0x1C84. Counter n uses bits [8*(n mod 4)+7 : 8*(n mod 4)]. The event is present when `evt_pulse[code]` is 1.
- R5: Event code 0x00 is present on every cycle, whatever `evt_pulse[0]` holds.
- R6: An increment that takes counter n from all ones to zero sets bit n of the status register at 0x1C78.
- R7: `irq` is high exactly when some status bit n is 1 while bit n of the mask register at 0x1C70 is 0. A mask bit of 1 masks that counter.
- R8: Writing a 1 to bit n of 0x1C7C clears status bit n. A 0 bit leaves its status bit unchanged. The register reads as 0.
- R9: If counter n wraps on the same edge as a write that clears status bit n, the status bit ends up 1.
- R10: A bus write to a counter on the same edge as an increment of that counter stores the written value. No increment and no wrap happen on that edge.
- R11: Bit 9 of the register at 0x0534 is stored and drives `pm_off`, and its other bits read 0. The word at 0x1CF0 reads the VERSION parameter and ignores writes.
- R12: Any address not listed above reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 64 | Write data (32-bit data in bits 31:0) |
| bus_rdata | output | 64 | Read data for `bus_addr`, same cycle |
| evt_pulse | input | 256 | Event pulses, bit k = event code k |
| irq | output | 1 | Overflow interrupt |
| pm_off | output | 1 | Power-management override bit |

## Verification
Read data is due in the same cycle as the address, so the bench samples it 1 ns after driving the address in the low clock phase. Writes and increments land on the next rising edge. Status bits are set on the edge of the wrapping increment, and `irq` follows combinationally in that same cycle. Every check therefore samples at a falling edge after the edge that must have acted.

The cycle-count test relies on the run bit being sampled before it is written. A counter on code 0x00 counts one more edge than the number of full cycles the bench waits between its start and stop writes. The bench computes that K+1 figure itself.

// File: rtl/evcu_pkg.sv
package evcu_pkg;
  localparam logic [15:0] A_CTRL  = 16'h1C00;
  localparam logic [15:0] A_CNTEN = 16'h1C04;
  localparam logic [15:0] A_MASK  = 16'h1C70;
  localparam logic [15:0] A_STAT  = 16'h1C78;
  localparam logic [15:0] A_CLR   = 16'h1C7C;
  localparam logic [15:0] A_SEL0  = 16'h1C80;
  localparam logic [15:0] A_VER   = 16'h1CF0;
  localparam logic [15:0] A_CNT0  = 16'h1D00;
  localparam logic [15:0] A_CFG   = 16'h0534;
  localparam int          PM_BIT  = 9;

  function automatic logic [15:0] cnt_addr(input int n);
    return A_CNT0 + 16'(8 * n);
  endfunction

  function automatic logic [15:0] sel_addr(input int w);
    return A_SEL0 + 16'(4 * w);
  endfunction
endpackage

// File: rtl/evcu_cnt_slice.sv
module evcu_cnt_slice #(
  parameter int CNT_W  = 64,
  parameter int CODE_W = 8,
  localparam int NCODES = 1 << CODE_W,
  localparam int HALF   = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              en,
  input  logic [CODE_W-1:0] code,
  input  logic [NCODES-1:0] evt,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  cnt,
  output logic              inc,
  output logic              wrap
);
  logic hit;
  logic sw_wr;

  assign hit   = (code == '0) ? 1'b1 : evt[code];
  assign sw_wr = wr_lo | wr_hi;
  assign inc   = run & en & hit & ~sw_wr;
  assign wrap  = inc & (&cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (sw_wr) begin
      if (wr_lo) cnt[HALF-1:0]     <= wr_data[HALF-1:0];
      if (wr_hi) cnt[CNT_W-1:HALF] <= wr_data[CNT_W-1:HALF];
    end else if (inc) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/evcu_irq.sv
module evcu_irq #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] wrap,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] mask,
  output logic [N-1:0] status,
  output logic         irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~clr) | wrap;
  end

  assign irq = |(status & ~mask);
endmodule

// File: rtl/evt_counter_unit.sv
module evt_counter_unit #(
  parameter int          NUM_CNT = 8,
  parameter int          CNT_W   = 64,
  parameter int          CODE_W  = 8,
  parameter logic [31:0] VERSION = 32'h0001_0300,
  localparam int NCODES = 1 << CODE_W,
  localparam int LANES  = 32 / CODE_W,
  localparam int NSEL   = (NUM_CNT + LANES - 1) / LANES,
  localparam int HALF   = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_wide,
  input  logic [15:0]       bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic [NCODES-1:0] evt_pulse,
  output logic              irq,
  output logic              pm_off
);
  import evcu_pkg::*;

  logic               run_q;
  logic [NUM_CNT-1:0] en_q;
  logic [NUM_CNT-1:0] mask_q;
  logic [31:0]        sel_q [NSEL];
  logic               pm_q;

  logic               wr_en;
  logic [NUM_CNT-1:0] cnt_lo_wr, cnt_hi_wr, cnt_wr;
  logic [NUM_CNT-1:0] cnt_inc, wrap_vec, clr_vec, status;
  logic [CNT_W-1:0]   cnt_q [NUM_CNT];
  logic [CNT_W-1:0]   slice_wdata;
  logic               addr_hit;

  assign wr_en       = bus_valid & bus_write;
  assign slice_wdata = bus_wide ? bus_wdata : {bus_wdata[HALF-1:0], bus_wdata[HALF-1:0]};
  assign clr_vec     = (wr_en && bus_addr == A_CLR) ? bus_wdata[NUM_CNT-1:0] : '0;
  assign cnt_wr      = cnt_lo_wr | cnt_hi_wr;
  assign pm_off      = pm_q;

  always_comb begin
    for (int k = 0; k < NUM_CNT; k++) begin
      cnt_lo_wr[k] = wr_en && (bus_addr == cnt_addr(k));
      cnt_hi_wr[k] = wr_en && ((bus_wide && bus_addr == cnt_addr(k)) ||
                               (!bus_wide && bus_addr == cnt_addr(k) + 16'd4));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      en_q   <= '0;
      mask_q <= '1;
      pm_q   <= 1'b0;
      for (int k = 0; k < NSEL; k++) sel_q[k] <= '0;
    end else if (wr_en) begin
      if (bus_addr == A_CTRL)  run_q  <= bus_wdata[0];
      if (bus_addr == A_CNTEN) en_q   <= bus_wdata[NUM_CNT-1:0];
      if (bus_addr == A_MASK)  mask_q <= bus_wdata[NUM_CNT-1:0];
      if (bus_addr == A_CFG)   pm_q   <= bus_wdata[PM_BIT];
      for (int k = 0; k < NSEL; k++)
        if (bus_addr == sel_addr(k)) sel_q[k] <= bus_wdata[31:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    addr_hit  = 1'b1;
    if (bus_addr == A_CTRL)       bus_rdata = CNT_W'(run_q);
    else if (bus_addr == A_CNTEN) bus_rdata = CNT_W'(en_q);
    else if (bus_addr == A_MASK)  bus_rdata = CNT_W'(mask_q);
    else if (bus_addr == A_STAT)  bus_rdata = CNT_W'(status);
    else if (bus_addr == A_CLR)   bus_rdata = '0;
    else if (bus_addr == A_VER)   bus_rdata = CNT_W'(VERSION);
    else if (bus_addr == A_CFG)   bus_rdata = CNT_W'({pm_q, 9'd0});
    else begin
      addr_hit = 1'b0;
      for (int k = 0; k < NSEL; k++)
        if (bus_addr == sel_addr(k)) begin
          bus_rdata = CNT_W'(sel_q[k]);
          addr_hit  = 1'b1;
        end
      for (int k = 0; k < NUM_CNT; k++) begin
        if (bus_addr == cnt_addr(k)) begin
          bus_rdata = bus_wide ? cnt_q[k] : CNT_W'(cnt_q[k][HALF-1:0]);
          addr_hit  = 1'b1;
        end else if (!bus_wide && bus_addr == cnt_addr(k) + 16'd4) begin
          bus_rdata = CNT_W'(cnt_q[k][CNT_W-1:HALF]);
          addr_hit  = 1'b1;
        end
      end
    end
  end

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
    evcu_cnt_slice #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_slice (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run_q),
      .en      (en_q[n]),
      .code    (sel_q[n / LANES][(n % LANES) * CODE_W +: CODE_W]),
      .evt     (evt_pulse),
      .wr_lo   (cnt_lo_wr[n]),
      .wr_hi   (cnt_hi_wr[n]),
      .wr_data (slice_wdata),
      .cnt     (cnt_q[n]),
      .inc     (cnt_inc[n]),
      .wrap    (wrap_vec[n])
    );
  end

  evcu_irq #(.N(NUM_CNT)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .wrap   (wrap_vec),
    .clr    (clr_vec),
    .mask   (mask_q),
    .status (status),
    .irq    (irq)
  );
endmodule

// File: rtl/evcu_chk.sv
module evcu_chk #(
  parameter int N = 8,
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run_q,
  input logic [N-1:0] cnt_inc,
  input logic [N-1:0] cnt_wr,
  input logic [N-1:0] wrap_vec,
  input logic [N-1:0] clr_vec,
  input logic [N-1:0] status,
  input logic [N-1:0] mask_q,
  input logic         irq,
  input logic         addr_hit,
  input logic [W-1:0] bus_rdata
);
  p_stopped_no_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> cnt_inc == '0);

  p_wrap_sets_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_vec != '0 |=> (status & $past(wrap_vec)) == $past(wrap_vec));

  p_masked_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~mask_q) == '0 |-> !irq);

  p_sticky_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    status != '0 |=> (($past(status) & ~$past(clr_vec)) & ~status) == '0);

  p_write_beats_inc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_inc | wrap_vec) & cnt_wr) == '0);

  p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_hit |-> bus_rdata == '0);
endmodule

bind evt_counter_unit evcu_chk #(.N(NUM_CNT), .W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run_q     (run_q),
  .cnt_inc   (cnt_inc),
  .cnt_wr    (cnt_wr),
  .wrap_vec  (wrap_vec),
  .clr_vec   (clr_vec),
  .status    (status),
  .mask_q    (mask_q),
  .irq       (irq),
  .addr_hit  (addr_hit),
  .bus_rdata (bus_rdata)
);

// File: tb/tb_evt_counter_unit.sv
`timescale 1ns/1ps
module tb_evt_counter_unit;
  localparam logic [31:0] VER = 32'h0001_0300;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0, bus_wide = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic [255:0] evt_pulse = '0;
  logic        irq, pm_off;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  evt_counter_unit #(.VERSION(VER)) dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_wide(bus_wide), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .evt_pulse(evt_pulse), .irq(irq), .pm_off(pm_off)
  );

  function automatic logic [15:0] caddr(input int n);
    return 16'h1D00 + 16'(n * 8);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [63:0] d, input logic w);
    bus_valid = 1; bus_write = 1; bus_wide = w; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [15:0] a, input logic w, output logic [63:0] d);
    bus_valid = 1; bus_write = 0; bus_wide = w; bus_addr = a;
    #1 d = bus_rdata;
    bus_valid = 0;
  endtask

  task automatic pulse(input int code, input int times);
    for (int t = 0; t < times; t++) begin
      evt_pulse[code] = 1'b1;
      @(posedge clk); @(negedge clk);
      evt_pulse = '0;
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(16'h1C70, 0, d); chk("R1 mask", d, 64'hFF);
    rd(16'h1C78, 0, d); chk("R1 status", d, 0);
    rd(16'h1C04, 0, d); chk("R1 enables", d, 0);
    rd(16'h1C00, 0, d); chk("R1 run", d, 0);
    rd(16'h1C80, 0, d); chk("R1 select", d, 0);
    for (int n = 0; n < 8; n++) begin
      rd(caddr(n), 1, d); chk("R1 counter", d, 0);
    end
    chk("R1 irq", 64'(irq), 0);

    // R11 version and configuration
    rd(16'h1CF0, 0, d); chk("R11 version", d, 64'(VER));
    wr(16'h1CF0, 64'h5555, 0);
    rd(16'h1CF0, 0, d); chk("R11 version write ignored", d, 64'(VER));
    chk("R11 pm_off reset", 64'(pm_off), 0);
    wr(16'h0534, 64'hFFFF_FFFF, 0);
    rd(16'h0534, 0, d); chk("R11 cfg bit9 only", d, 64'h200);
    chk("R11 pm_off set", 64'(pm_off), 1);

    // R12 unmapped
    wr(16'h1C08, 64'hFFFF, 0);
    rd(16'h1C08, 0, d); chk("R12 unmapped read", d, 0);
    rd(16'h1D40, 0, d); chk("R12 past last counter", d, 0);
    rd(16'h1C7C, 0, d); chk("R8 clear reads zero", d, 0);

    // R4 lane mapping: counter n on code 0x10+n, code 0x10+i pulsed i+1 times
    wr(16'h1C80, 64'h1312_1110, 0);
    wr(16'h1C84, 64'h1716_1514, 0);
    rd(16'h1C84, 0, d); chk("R4 select readback", d, 64'h1716_1514);
    wr(16'h1C04, 64'hFF, 0);
    wr(16'h1C00, 64'h1, 0);
    for (int i = 0; i < 8; i++) pulse(16'h10 + i, i + 1);
    wr(16'h1C00, 64'h0, 0);
    for (int n = 0; n < 8; n++) begin
      rd(caddr(n), 1, d); chk("R4 per-lane count", d, 64'(n + 1));
    end

    // R3 gating by run and per-counter enable
    for (int i = 0; i < 8; i++) pulse(16'h10 + i, 1);
    for (int n = 0; n < 8; n++) begin
      rd(caddr(n), 1, d); chk("R3 stopped", d, 64'(n + 1));
    end
    wr(16'h1C04, 64'hF7, 0);
    wr(16'h1C00, 64'h1, 0);
    for (int i = 0; i < 8; i++) pulse(16'h10 + i, 1);
    wr(16'h1C00, 64'h0, 0);
    for (int n = 0; n < 8; n++) begin
      rd(caddr(n), 1, d); chk("R3 enable gate", d, (n == 3) ? 64'd4 : 64'(n + 2));
    end

    // R5 cycle code: counter 5 on code 0, K waited cycles -> K+1 edges counted
    wr(caddr(5), 64'h0, 1);
    wr(16'h1C84, 64'h1716_0014, 0);
    wr(16'h1C04, 64'h20, 0);
    wr(16'h1C00, 64'h1, 0);
    repeat (10) @(negedge clk);
    wr(16'h1C00, 64'h0, 0);
    rd(caddr(5), 1, d); chk("R5 cycle count", d, 64'd11);

    // R2 halves
    wr(caddr(7) + 16'd4, 64'hDEAD_BEEF, 0);
    wr(caddr(7), 64'h0123_4567, 0);
    rd(caddr(7), 1, d); chk("R2 full read", d, 64'hDEAD_BEEF_0123_4567);
    rd(caddr(7) + 16'd4, 0, d); chk("R2 high half", d, 64'hDEAD_BEEF);
    rd(caddr(7), 0, d); chk("R2 low half", d, 64'h0123_4567);

    // R6 wrap sets status, R7 masking
    wr(16'h1C80, 64'h1361_1110, 0);
    wr(16'h1C04, 64'h04, 0);
    wr(caddr(2), 64'hFFFF_FFFF_FFFF_FFFE, 1);
    wr(16'h1C00, 64'h1, 0);
    pulse(16'h61, 2);
    rd(caddr(2), 1, d); chk("R6 wrapped value", d, 0);
    rd(16'h1C78, 0, d); chk("R6 status", d, 64'h04);
    chk("R7 masked irq", 64'(irq), 0);
    wr(16'h1C70, 64'hFB, 0);
    chk("R7 unmasked irq", 64'(irq), 1);

    // R8 write-one-to-clear
    wr(16'h1C7C, 64'hFB, 0);
    rd(16'h1C78, 0, d); chk("R8 zero bits ignored", d, 64'h04);
    chk("R8 irq held", 64'(irq), 1);
    wr(16'h1C7C, 64'h04, 0);
    rd(16'h1C78, 0, d); chk("R8 cleared", d, 0);
    chk("R8 irq dropped", 64'(irq), 0);

    // R9 wrap and clear on the same edge
    wr(caddr(2), 64'hFFFF_FFFF_FFFF_FFFF, 1);
    bus_valid = 1; bus_write = 1; bus_wide = 0; bus_addr = 16'h1C7C; bus_wdata = 64'h04;
    evt_pulse[16'h61] = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_valid = 0; bus_write = 0; evt_pulse = '0;
    rd(16'h1C78, 0, d); chk("R9 wrap beats clear", d, 64'h04);
    rd(caddr(2), 1, d); chk("R9 counter wrapped", d, 0);

    // R10 software write beats increment, and suppresses wrap
    wr(16'h1C7C, 64'hFF, 0);
    bus_valid = 1; bus_write = 1; bus_wide = 1; bus_addr = caddr(2); bus_wdata = 64'h100;
    evt_pulse[16'h61] = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_valid = 0; bus_write = 0; evt_pulse = '0;
    rd(caddr(2), 1, d); chk("R10 write wins", d, 64'h100);
    wr(caddr(2), 64'hFFFF_FFFF_FFFF_FFFF, 1);
    bus_valid = 1; bus_write = 1; bus_wide = 1; bus_addr = caddr(2); bus_wdata = 64'hFFFF_FFFF_FFFF_FFFF;
    evt_pulse[16'h61] = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_valid = 0; bus_write = 0; evt_pulse = '0;
    rd(16'h1C78, 0, d); chk("R10 no wrap on write", d, 0);
    rd(caddr(2), 1, d); chk("R10 all ones kept", d, 64'hFFFF_FFFF_FFFF_FFFF);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule